// File: doc/BRIEF.md
# Banked Register File Read Crossbar

This block routes register-file read requests from a set of requesters onto the read ports of a banked register file. Every requester presents a valid flag and a register address. The upper part of the address names the bank, and the lower part names the register inside that bank. Every bank read port has a ready input and returns data. The block picks at most one requester for each bank port, forwards that requester's address to the port, acknowledges the requester and sends the port's data back to it.

Each bank port has a set of candidate requesters. There are two candidate maps. In the full map every requester is a candidate of every port. In the strided map a port sees only every P-th requester, offset by the port's own number. Bank ports are served in a fixed order: bank by bank, and inside a bank by rising port number. A requester granted by an earlier port is no longer available to later ports.

The block is purely combinational and keeps no state between cycles. Because a bank port's ready feeds its output valid, the surrounding logic must not make ready depend on valid.

Top module: `rfx_bank_read_xbar`

## Requirements
- R1: The bank index of a request is `addr[AW-1:SHIFT]`. Bits `addr[SHIFT-1:0]` select the register inside the bank.
- R2: With `MODE = XBAR_FULL` (0), candidate k of every bank port is requester k, for k = 0..N-1.
- R3: With `MODE = XBAR_STRIDED` (1), candidate k of bank port j (the port number inside its bank) is requester k*P+j, for k = 0..ceil(N/P)-1. Candidates whose index is N or more do not exist, and their select-valid is 0.
- R4: The select-valid bit of a candidate is high exactly when three conditions hold: the port's ready is high, the candidate has not been granted by an earlier port, and the candidate's bank index equals the port's bank.
- R5: A requester whose valid is low is never selected, never acknowledged and never granted.
- R6: Inside one bank port, only the lowest-numbered candidate with select-valid high gets the grant. Each port grants at most one candidate.
- R7: Global bank-port order is l = bank*P + port. A requester granted by port l is unavailable to every port after l, so each requester is granted at most once.
- R8: A bank port whose ready is low has all select-valid bits low, grants nothing and drives its valid low.
- R9: A granted requester sees ack high and its data equals the data input of the bank port that granted it. A requester that is not granted sees ack low and data 0.
- R10: A bank port with a grant drives valid high and the address {bank index, granted requester's `addr[SHIFT-1:0]`}. Without a grant it drives valid low and address 0.
- R11: A request whose bank index is B or higher matches no bank and is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | N | Per-requester request valid |
| req_addr | input | N*AW | Requester addresses, requester r at bits [r*AW +: AW] |
| req_ack | output | N | Per-requester grant acknowledge |
| req_data | output | N*DW | Returned data, requester r at [r*DW +: DW] |
| bank_ready | input | B*P | Bank port ready, port l = bank*P+port |
| bank_valid | output | B*P | Bank port carries a granted request |
| bank_addr | output | B*P*AW | Address forwarded to bank port l at [l*AW +: AW] |
| bank_data | input | B*P*DW | Data returned by bank port l at [l*DW +: DW] |
| sel_valid | output | B*P*NC | Candidate k of port l eligible, bit l*NC+k |
| sel_grant | output | B*P*NC | Candidate k of port l granted, bit l*NC+k |

## Verification
The bench drives two instances with the same inputs: one uses the full map and one uses the strided map, so any change to the candidate map shows up as a difference from the priority model. A fixed vector table sets up three kinds of conflict:
- several requesters aiming at the same bank, which tests the lowest-candidate-first rule;
- more requesters for a bank than it has ports, which tests the earlier-port busy marking;
- requests to nonexistent banks, or with ready low, which must stay unserved.

Directed cases then cover an all-idle input, all ports not ready, and a lone high-index requester. Random traffic follows, mixing valid, ready and bank patterns.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    typedef enum logic {
        XBAR_FULL    = 1'b0,
        XBAR_STRIDED = 1'b1
    } xbar_mode_e;

    // Number of candidate slots per bank port.
    function automatic int unsigned cand_count(xbar_mode_e mode, int unsigned n_req,
                                               int unsigned n_port);
        return (mode == XBAR_FULL) ? n_req : (n_req + n_port - 1) / n_port;
    endfunction

    // Requester index feeding candidate slot k of port j.
    function automatic int unsigned cand_req(xbar_mode_e mode, int unsigned k,
                                             int unsigned j, int unsigned n_port);
        return (mode == XBAR_FULL) ? k : k * n_port + j;
    endfunction

endpackage

// File: rtl/rfx_port_stage.sv
module rfx_port_stage
    import rfx_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned AW    = 6,
    parameter int unsigned SHIFT = 4,
    parameter int unsigned P     = 2,
    parameter int unsigned NC    = 4,
    parameter int unsigned BANK  = 0,
    parameter int unsigned PORT  = 0,
    parameter xbar_mode_e  MODE  = XBAR_FULL
) (
    input  logic                 port_ready,
    input  logic [N-1:0]         busy_in,
    input  logic [N*AW-1:0]      req_addr,
    output logic [N-1:0]         busy_out,
    output logic [N-1:0]         grant_req,
    output logic [NC-1:0]        sel_valid,
    output logic [NC-1:0]        sel_grant,
    output logic                 out_valid,
    output logic [AW-1:0]        out_addr
);
    localparam int unsigned   BW      = AW - SHIFT;
    localparam logic [BW-1:0] BANK_ID = BW'(BANK);

    logic [NC-1:0][N-1:0] cand_oh;
    logic [SHIFT-1:0]     low_bits;

    // Candidate map: a constant requester index per slot
    for (genvar k = 0; k < NC; k++) begin : g_cand
        localparam int unsigned RIDX = cand_req(MODE, k, PORT, P);
        if (RIDX < N) begin : g_live
            assign cand_oh[k]   = N'(1) << RIDX;
            assign sel_valid[k] = port_ready & ~busy_in[RIDX]
                                & (req_addr[RIDX*AW+SHIFT +: BW] == BANK_ID);
        end else begin : g_none
            assign cand_oh[k]   = '0;
            assign sel_valid[k] = 1'b0;
        end
    end

    // Lowest eligible slot wins
    always_comb begin : b_pick
        logic taken;
        taken     = 1'b0;
        grant_req = '0;
        for (int i = 0; i < NC; i++) begin
            sel_grant[i] = sel_valid[i] & ~taken;
            if (sel_grant[i]) grant_req = grant_req | cand_oh[i];
            taken = taken | sel_valid[i];
        end
    end

    always_comb begin : b_addr
        low_bits = '0;
        for (int r = 0; r < N; r++)
            if (grant_req[r]) low_bits = low_bits | req_addr[r*AW +: SHIFT];
        out_valid = |grant_req;
        out_addr  = out_valid ? {BANK_ID, low_bits} : '0;
        busy_out  = busy_in | grant_req;
    end

    always_comb begin : b_chk
        AST_ONE_GRANT: assert ($onehot0(sel_grant)) else $error("two grants on one port"); // R6
        AST_GRANT_NEEDS_SEL: assert ((sel_grant & ~sel_valid) == '0) else $error("grant without select"); // R4
        AST_NO_REGRANT: assert ((grant_req & busy_in) == '0) else $error("busy requester granted"); // R7
        if (!port_ready) begin
            AST_IDLE_NOT_READY: assert (!out_valid && sel_valid == '0) else $error("activity while not ready"); // R8
        end
        if (out_valid) begin
            AST_ADDR_BANK: assert (out_addr[AW-1:SHIFT] == BANK_ID) else $error("wrong bank field"); // R10
        end
    end

endmodule

// File: rtl/rfx_return_mux.sv
module rfx_return_mux #(
    parameter int unsigned N  = 4,
    parameter int unsigned L  = 4,
    parameter int unsigned DW = 8
) (
    input  logic [L*N-1:0]  port_grant,
    input  logic [L*DW-1:0] port_data,
    output logic [N-1:0]    req_ack,
    output logic [N*DW-1:0] req_data
);
    for (genvar r = 0; r < N; r++) begin : g_req
        logic [L-1:0] hits;
        for (genvar l = 0; l < L; l++) begin : g_hit
            assign hits[l] = port_grant[l*N + r];
        end

        always_comb begin : b_sel
            req_data[r*DW +: DW] = '0;
            for (int l = 0; l < L; l++)
                if (hits[l]) req_data[r*DW +: DW] = req_data[r*DW +: DW] | port_data[l*DW +: DW];
        end
        assign req_ack[r] = |hits;

        always_comb begin : b_chk
            AST_SINGLE_OWNER: assert ($countones(hits) <= 1) else $error("requester served twice"); // R7
        end
    end

endmodule

// File: rtl/rfx_bank_read_xbar.sv
module rfx_bank_read_xbar
    import rfx_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned B     = 2,
    parameter int unsigned P     = 2,
    parameter int unsigned AW    = 6,
    parameter int unsigned DW    = 8,
    parameter int unsigned SHIFT = 4,
    parameter xbar_mode_e  MODE  = XBAR_FULL,
    localparam int unsigned L    = B * P,
    localparam int unsigned NC   = cand_count(MODE, N, P)
) (
    input  logic [N-1:0]      req_valid,
    input  logic [N*AW-1:0]   req_addr,
    output logic [N-1:0]      req_ack,
    output logic [N*DW-1:0]   req_data,
    input  logic [L-1:0]      bank_ready,
    output logic [L-1:0]      bank_valid,
    output logic [L*AW-1:0]   bank_addr,
    input  logic [L*DW-1:0]   bank_data,
    output logic [L*NC-1:0]   sel_valid,
    output logic [L*NC-1:0]   sel_grant
);
    logic [L:0][N-1:0] busy_chain;
    logic [L*N-1:0]    port_grant;

    // Idle requesters start out busy
    assign busy_chain[0] = ~req_valid;

    for (genvar b = 0; b < B; b++) begin : g_bank
        for (genvar p = 0; p < P; p++) begin : g_port
            localparam int unsigned LI = b * P + p;
            rfx_port_stage #(
                .N(N), .AW(AW), .SHIFT(SHIFT), .P(P), .NC(NC),
                .BANK(b), .PORT(p), .MODE(MODE)
            ) i_stage (
                .port_ready (bank_ready[LI]),
                .busy_in    (busy_chain[LI]),
                .req_addr   (req_addr),
                .busy_out   (busy_chain[LI+1]),
                .grant_req  (port_grant[LI*N +: N]),
                .sel_valid  (sel_valid[LI*NC +: NC]),
                .sel_grant  (sel_grant[LI*NC +: NC]),
                .out_valid  (bank_valid[LI]),
                .out_addr   (bank_addr[LI*AW +: AW])
            );
        end
    end

    rfx_return_mux #(.N(N), .L(L), .DW(DW)) i_ret (
        .port_grant (port_grant),
        .port_data  (bank_data),
        .req_ack    (req_ack),
        .req_data   (req_data)
    );

    always_comb begin : b_chk
        AST_ACK_NEEDS_VALID: assert ((req_ack & ~req_valid) == '0) else $error("idle requester acked"); // R5
    end

endmodule

// File: tb/test_rfx_bank_read_xbar.sv
`timescale 1ns/1ps
module test_rfx_bank_read_xbar;
    import rfx_pkg::*;

    localparam int unsigned N = 4, B = 2, P = 2, AW = 6, DW = 8, SH = 4;
    localparam int unsigned L = B * P, NCF = 4, NCS = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [N-1:0]    v;
    logic [N*AW-1:0] a;
    logic [L-1:0]    rdy;
    logic [L*DW-1:0] bd;

    logic [N-1:0] f_ack, s_ack;
    logic [N*DW-1:0] f_data, s_data;
    logic [L-1:0] f_val, s_val;
    logic [L*AW-1:0] f_addr, s_addr;
    logic [L*NCF-1:0] f_sel, f_grt;
    logic [L*NCS-1:0] s_sel, s_grt;

    rfx_bank_read_xbar #(.N(N), .B(B), .P(P), .AW(AW), .DW(DW), .SHIFT(SH), .MODE(XBAR_FULL))
    i_rfx_bank_read_xbar (
        .req_valid(v), .req_addr(a), .req_ack(f_ack), .req_data(f_data),
        .bank_ready(rdy), .bank_valid(f_val), .bank_addr(f_addr), .bank_data(bd),
        .sel_valid(f_sel), .sel_grant(f_grt));

    rfx_bank_read_xbar #(.N(N), .B(B), .P(P), .AW(AW), .DW(DW), .SHIFT(SH), .MODE(XBAR_STRIDED))
    i_rfx_bank_read_xbar_s (
        .req_valid(v), .req_addr(a), .req_ack(s_ack), .req_data(s_data),
        .bank_ready(rdy), .bank_valid(s_val), .bank_addr(s_addr), .bank_data(bd),
        .sel_valid(s_sel), .sel_grant(s_grt));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected values from the priority model
    logic [N-1:0]    e_ack;
    logic [N*DW-1:0] e_data;
    logic [L-1:0]    e_val;
    logic [L*AW-1:0] e_addr;
    logic [L*NCF-1:0] e_sel, e_grt;

    task automatic model(input bit strided);
        logic [N-1:0] busy;
        busy = ~v;
        e_ack = '0; e_data = '0; e_val = '0; e_addr = '0; e_sel = '0; e_grt = '0;
        for (int l = 0; l < L; l++) begin
            int unsigned bk, j, nc;
            bit found;
            bk = l / P; j = l % P;
            nc = strided ? NCS : NCF;
            found = 1'b0;
            for (int k = 0; k < nc; k++) begin
                int unsigned r;
                bit sv;
                r  = strided ? k * P + j : k;                     // R2 / R3
                sv = (r < N) && rdy[l] && !busy[r]
                     && (a[r*AW+SH +: AW-SH] == (AW-SH)'(bk));     // R1 / R4
                e_sel[l*NCF+k] = sv;
                if (sv && !found) begin                            // R6
                    found = 1'b1;
                    busy[r] = 1'b1;                                // R7
                    e_grt[l*NCF+k] = 1'b1;
                    e_ack[r] = 1'b1;
                    e_data[r*DW +: DW] = bd[l*DW +: DW];           // R9
                    e_val[l] = 1'b1;
                    e_addr[l*AW +: AW] = {(AW-SH)'(bk), a[r*AW +: SH]}; // R10
                end
            end
        end
    endtask

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_inst(input bit strided, input string ctx);
        model(strided);
        if (!strided) begin
            cmp({ctx, " full R9 ack"},  64'(f_ack),  64'(e_ack));
            cmp({ctx, " full R9 data"}, 64'(f_data), 64'(e_data));
            cmp({ctx, " full R10 valid"}, 64'(f_val), 64'(e_val));
            cmp({ctx, " full R10 addr"},  64'(f_addr), 64'(e_addr));
            cmp({ctx, " full R2 R4 sel"}, 64'(f_sel),  64'(e_sel));
            cmp({ctx, " full R6 grant"},  64'(f_grt),  64'(e_grt));
        end else begin
            logic [L*NCS-1:0] es, eg;
            for (int l = 0; l < L; l++)
                for (int k = 0; k < NCS; k++) begin
                    es[l*NCS+k] = e_sel[l*NCF+k];
                    eg[l*NCS+k] = e_grt[l*NCF+k];
                end
            cmp({ctx, " strided R9 ack"},  64'(s_ack),  64'(e_ack));
            cmp({ctx, " strided R9 data"}, 64'(s_data), 64'(e_data));
            cmp({ctx, " strided R10 valid"}, 64'(s_val), 64'(e_val));
            cmp({ctx, " strided R10 addr"},  64'(s_addr), 64'(e_addr));
            cmp({ctx, " strided R3 R4 sel"}, 64'(s_sel),  64'(es));
            cmp({ctx, " strided R6 grant"},  64'(s_grt),  64'(eg));
        end
    endtask

    task automatic apply(input logic [N-1:0] vv, input logic [N*AW-1:0] aa,
                         input logic [L-1:0] rr, input string ctx);
        @(negedge clk);
        v = vv; a = aa; rdy = rr;
        #1;
        check_inst(1'b0, ctx);
        check_inst(1'b1, ctx);
    endtask

    // {valid[3:0], addr3, addr2, addr1, addr0, ready[3:0]}
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {4'hF, 6'h04, 6'h03, 6'h02, 6'h01, 4'hF},  // all to bank 0: R6 R7
        {4'hF, 6'h14, 6'h13, 6'h02, 6'h01, 4'hF},  // two per bank
        {4'hF, 6'h14, 6'h13, 6'h12, 6'h11, 4'hF},  // all to bank 1: R7
        {4'h5, 6'h04, 6'h03, 6'h02, 6'h01, 4'hF},  // gaps in valid: R5
        {4'hF, 6'h34, 6'h23, 6'h12, 6'h01, 4'hF},  // banks 2,3 absent: R11
        {4'hF, 6'h14, 6'h13, 6'h02, 6'h01, 4'hA},  // port 0 of each bank not ready: R8
        {4'hE, 6'h1F, 6'h0E, 6'h1D, 6'h0C, 4'h6},  // mixed
        {4'h8, 6'h15, 6'h00, 6'h00, 6'h00, 4'hC}   // lone high requester
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        v = '0; a = '0; rdy = '0;
        for (int l = 0; l < L; l++) bd[l*DW +: DW] = DW'(8'h31 + 8'h22 * l);
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset / idle state: nothing valid, everything quiet (R5, R9, R10)
        apply('0, '0, '1, "idle R5");

        for (int i = 0; i < NV; i++)
            apply(VEC[i][31:28], VEC[i][27:4], VEC[i][3:0], $sformatf("vec%0d", i));

        // No port ready: no grants at all (R8)
        apply(4'hF, {6'h11, 6'h01, 6'h10, 6'h00}, '0, "noready R8");
        // Only requester 3 to bank 1: full grants it on port 2, strided on port 3 (R2 R3)
        apply(4'h8, {6'h17, 18'h0}, '1, "lone R2 R3");
        // Every request outside existing banks (R11)
        apply(4'hF, {6'h3F, 6'h2A, 6'h35, 6'h20}, '1, "nobank R11");
        // Register field preserved in forwarded address (R1)
        apply(4'h3, {12'h0, 6'h1B, 6'h06}, '1, "regfield R1");

        for (int i = 0; i < 300; i++)
            apply(N'($urandom), (N*AW)'({$urandom, $urandom}), L'($urandom), "random");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule